// File: doc/BRIEF.md
# Three-Wire Paged Register Bus Master

This block lets a host reach a small external register file over a three-wire serial link. The link has a clock line, a data line that is driven in both directions, and a direction line that is high while the master talks and low while it listens. The host presents one byte-wide access at a time on a request/done port. It gives a 5-bit logical address, a write flag and a write byte. The block splits the logical address into a bank number (1 or 2) and a local offset. It keeps a record of the bank the external device last selected. It spends a separate bank-select write cycle only when the target bank differs from that record.

A write cycle carries the data byte first and the local offset second. A read cycle carries only the offset. The master then releases the data line and clocks eight reply bits in. Bits go least significant first. Each bit period is a low half followed by a high half, and each half lasts `HALF_CYC` system clocks. While the `powered` input is low, requests finish at once with no activity on the link. When `powered` rises again, the bank record is cleared to 0, which means no valid bank, so the next access always reselects its bank.

The controller is a single state machine. ST_IDLE waits for a request and goes to ST_SETUP if powered, or to ST_DONE if not. ST_SETUP raises the direction line and enables the driver, then goes to ST_SHLO. ST_SHLO (clock low, bit presented) always goes to ST_SHHI. ST_SHHI (clock high) goes back to ST_SHLO for the next bit or byte, or to ST_END after the last bit of the cycle. ST_END releases the driver and lowers the direction line. From ST_END the machine goes to ST_SETUP after a bank-select cycle, to ST_DONE after a write, or to ST_RDLO for a read. ST_RDLO (clock low, sample at its end) goes to ST_RDHI. ST_RDHI (clock high) goes to ST_RDLO, or to ST_DONE after the eighth bit. ST_DONE pulses `done` and returns to ST_IDLE. Every timed state lasts exactly one half period.

Top module: `tw_bus_master`

## Requirements
- R1: A logical address of 16 or more selects bank 2 with local offset address−16; a lower address selects bank 1 with offset equal to the address.
- R2: A bank-select write cycle is sent before an access only when the target bank differs from the cached bank. It carries the bank number byte, then the byte `BANK_REG`. The cache takes the new bank at the end of that cycle.
- R3: After reset, and on every rising edge of `powered`, the cached bank is 0, so the next powered access always performs a bank-select cycle.
- R4: Every bit period is `HALF_CYC` clocks with `bus_clk` low, then `HALF_CYC` clocks with `bus_clk` high. Bits go least significant first. `bus_data_o` does not change while `bus_clk` is high and the driver is on.
- R5: A write cycle is one `HALF_CYC` setup half, then the data byte, then the offset byte, then one `HALF_CYC` end half. `bus_rw` and `bus_data_oe` are high from setup through the last bit and low from the end half on.
- R6: A read sends only the offset byte in a write cycle. It then makes eight clock periods with the driver off and `bus_rw` low. It samples `bus_data_i` at the end of each low half, least significant bit first, and returns the byte on `rdata`.
- R7: `done` is high for exactly one cycle per accepted request. For a powered access it rises 34·`HALF_CYC` clocks after the accepting edge, or 68·`HALF_CYC` when a bank-select cycle is needed. `rdata` is 0 for writes.
- R8: A request accepted while `powered` is low gives `done` in the cycle right after the accepting edge. It returns `rdata` = 0, makes no transition on the link, and leaves the external registers unchanged.
- R9: A request raised while `busy` is high is ignored: it yields no `done` and no link activity.
- R10: Out of reset and between accesses, `bus_clk` is high, `bus_rw` is low and `bus_data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| powered | input | 1 | Link power flag; low makes accesses complete without bus activity |
| req | input | 1 | Access request, accepted when idle |
| req_we | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Logical register address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with done |
| busy | output | 1 | High while an access is in progress |
| bus_clk | output | 1 | Serial clock line |
| bus_rw | output | 1 | Direction line, high while the master transmits |
| bus_data_o | output | 1 | Serial data toward the device |
| bus_data_oe | output | 1 | Data line driver enable |
| bus_data_i | input | 1 | Serial data from the device |

## Verification
Each accepted request is due exactly 34·HALF_CYC or 68·HALF_CYC clocks after its accepting edge, depending on whether the bank must change. An unpowered request is due in the cycle right after that edge. The driver notes the cycle count at the accepting edge and queues the expected latency and read byte. The monitor samples `done` on the falling clock edge and compares the elapsed count exactly, so an early or late pulse fails. A bus model decodes the serial traffic and times every clock-low half. Its bank-switch and byte counters are compared after each stimulus, before the next one starts.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHLO,
        ST_SHHI,
        ST_END,
        ST_RDLO,
        ST_RDHI,
        ST_DONE
    } tw_state_e;
endpackage

// File: rtl/tw_addr_map.sv
module tw_addr_map #(
    parameter int ADDR_W = 5,
    parameter int SPLIT  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        bank,
    output logic [7:0]        offset
);
    logic              upper;
    logic [ADDR_W-1:0] local_addr;

    assign upper      = (addr >= ADDR_W'(SPLIT));
    assign bank       = upper ? 2'd2 : 2'd1;
    assign local_addr = upper ? (addr - ADDR_W'(SPLIT)) : addr;
    assign offset     = 8'(local_addr);
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(HALF_CYC));
endmodule

// File: rtl/tw_bus_master.sv
module tw_bus_master
    import tw_pkg::*;
#(
    parameter int         ADDR_W   = 5,
    parameter int         SPLIT    = 16,
    parameter int         HALF_CYC = 250,
    parameter logic [7:0] BANK_REG = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powered,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              bus_clk,
    output logic              bus_rw,
    output logic              bus_data_o,
    output logic              bus_data_oe,
    input  logic              bus_data_i
);
    tw_state_e state, nxt;

    logic       tick, run;
    logic [1:0] map_bank, bank_q, pend_bank, bank_eff;
    logic [7:0] map_off, off_q, wdata_q, sh_q, rdata_q, cur_byte;
    logic       we_q, in_bank, byte_sel, last_byte, pwr_q, pwr_rise;
    logic [2:0] bit_idx;

    tw_addr_map #(.ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_map (
        .addr   (req_addr),
        .bank   (map_bank),
        .offset (map_off)
    );

    assign run = (state != ST_IDLE) && (state != ST_DONE);

    tw_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    assign pwr_rise  = powered && !pwr_q;
    assign bank_eff  = pwr_rise ? 2'd0 : bank_q;
    assign last_byte = (in_bank || we_q) ? byte_sel : 1'b1;

    always_comb begin
        if (in_bank)
            cur_byte = byte_sel ? BANK_REG : {6'd0, pend_bank};
        else if (we_q)
            cur_byte = byte_sel ? off_q : wdata_q;
        else
            cur_byte = off_q;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req) nxt = powered ? ST_SETUP : ST_DONE;
            ST_SETUP: if (tick) nxt = ST_SHLO;
            ST_SHLO:  if (tick) nxt = ST_SHHI;
            ST_SHHI:  if (tick) nxt = (bit_idx == 3'd7 && last_byte) ? ST_END : ST_SHLO;
            ST_END:   if (tick) nxt = in_bank ? ST_SETUP : (we_q ? ST_DONE : ST_RDLO);
            ST_RDLO:  if (tick) nxt = ST_RDHI;
            ST_RDHI:  if (tick) nxt = (bit_idx == 3'd7) ? ST_DONE : ST_RDLO;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q    <= 2'd0;
            pend_bank <= 2'd0;
            pwr_q     <= 1'b0;
            we_q      <= 1'b0;
            off_q     <= '0;
            wdata_q   <= '0;
            in_bank   <= 1'b0;
            byte_sel  <= 1'b0;
            bit_idx   <= '0;
            sh_q      <= '0;
            rdata_q   <= '0;
        end else begin
            pwr_q <= powered;
            unique case (state)
                ST_IDLE: if (req) begin
                    rdata_q <= '0;
                    if (powered) begin
                        we_q      <= req_we;
                        off_q     <= map_off;
                        wdata_q   <= req_wdata;
                        pend_bank <= map_bank;
                        in_bank   <= (map_bank != bank_eff);
                        byte_sel  <= 1'b0;
                        bit_idx   <= '0;
                    end
                end
                ST_SHHI: if (tick) begin
                    if (bit_idx == 3'd7) begin
                        bit_idx <= '0;
                        if (!last_byte) byte_sel <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_END: if (tick) begin
                    byte_sel <= 1'b0;
                    bit_idx  <= '0;
                    if (in_bank) begin
                        in_bank <= 1'b0;
                        bank_q  <= pend_bank;
                    end
                end
                ST_RDLO: if (tick) sh_q <= {bus_data_i, sh_q[7:1]};
                ST_RDHI: if (tick) begin
                    if (bit_idx == 3'd7) begin
                        rdata_q <= sh_q;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: ;
            endcase
            if (pwr_rise) bank_q <= 2'd0;
        end
    end

    // outputs
    always_comb begin
        done        = (state == ST_DONE);
        busy        = (state != ST_IDLE);
        rdata       = rdata_q;
        bus_clk     = !((state == ST_SHLO) || (state == ST_RDLO));
        bus_rw      = (state == ST_SETUP) || (state == ST_SHLO) || (state == ST_SHHI);
        bus_data_oe = bus_rw;
        bus_data_o  = ((state == ST_SHLO) || (state == ST_SHHI)) ? cur_byte[bit_idx] : 1'b0;
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_unpowered_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !powered) |=> (done && bus_clk && !bus_rw && !bus_data_oe));

    assert_cache_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |=> (bank_q == 2'd0));

    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clk && $past(bus_clk) && bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_o));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(off_q) && $stable(we_q) && $stable(wdata_q)));
endmodule

// File: tb/sim_tw_bus_master.sv
`timescale 1ns/1ps
module sim_tw_bus_master;
    localparam int         H   = 4;
    localparam logic [7:0] BSR = 8'h01;

    logic       clk = 1'b0, rst_n = 1'b0, powered = 1'b1;
    logic       req = 1'b0, req_we = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       done, busy, bus_clk, bus_rw, bus_data_o, bus_data_oe;
    logic [7:0] rdata;
    logic       bus_data_i = 1'b0;

    always #2 clk = ~clk;

    tw_bus_master #(.ADDR_W(5), .SPLIT(16), .HALF_CYC(H), .BANK_REG(BSR)) u0 (
        .clk(clk), .rst_n(rst_n), .powered(powered), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .busy(busy), .bus_clk(bus_clk), .bus_rw(bus_rw), .bus_data_o(bus_data_o),
        .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] mem [1:2][0:15];
    int   bank_m = 0, nsw = 0, nbytes = 0, merr = 0, nb = 0, t_fall = 0, bad_low = 0;
    logic [7:0] sh_m = '0, rd_byte = '0;
    logic [7:0] rx [$];
    int   rd_idx = 0;
    bit   rd_act = 0;

    initial begin
        for (int b = 1; b <= 2; b++)
            for (int o = 0; o < 16; o++)
                mem[b][o] = 8'((b << 6) | o);
    end

    always @(posedge bus_clk) if (rst_n) begin
        if (cyc - t_fall != H) bad_low++;
        if (bus_data_oe === 1'b1) begin
            sh_m = {bus_data_o, sh_m[7:1]};
            nb++;
            if (nb == 8) begin rx.push_back(sh_m); nb = 0; nbytes++; end
        end
    end

    always @(negedge bus_clk) if (rst_n) begin
        t_fall = cyc;
        if (rd_act && !bus_rw) begin
            bus_data_i = rd_byte[rd_idx];
            rd_idx++;
            if (rd_idx == 8) rd_act = 0;
        end
    end

    always @(negedge bus_rw) if (rst_n) begin
        if (rx.size() == 2) begin
            if (rx[1] == BSR) begin bank_m = int'(rx[0]); nsw++; end
            else if (bank_m >= 1 && bank_m <= 2 && rx[1] < 16) mem[bank_m][rx[1][3:0]] = rx[0];
            else merr++;
        end else if (rx.size() == 1 && bank_m >= 1 && bank_m <= 2 && rx[0] < 16) begin
            rd_byte = mem[bank_m][rx[0][3:0]];
            rd_idx  = 0;
            rd_act  = 1;
        end else merr++;
        rx.delete();
        nb = 0;
    end

    // ---------------- scoreboard ----------------
    int         q_acc [$];
    int         q_lat [$];
    logic [7:0] q_rd  [$];
    string      q_tag [$];

    always @(negedge clk) if (rst_n && done) begin
        if (q_acc.size() == 0) begin
            chk(0, "R9 unexpected done", 1, 0);
        end else begin
            int a, l;
            logic [7:0] r;
            string t;
            a = q_acc.pop_front(); l = q_lat.pop_front();
            r = q_rd.pop_front();  t = q_tag.pop_front();
            chk(cyc - a == l, {t, " latency R7"}, cyc - a, l);
            chk(rdata == r, {t, " rdata"}, int'(rdata), int'(r));
        end
    end

    task automatic access(input bit we, input logic [4:0] a, input logic [7:0] d,
                          input int lat, input logic [7:0] exp_rd, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        q_acc.push_back(cyc); q_lat.push_back(lat); q_rd.push_back(exp_rd); q_tag.push_back(tag);
        @(negedge clk);
        req = 1'b0;
        while (q_acc.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    localparam int LS = 68 * H;  // with bank switch
    localparam int LN = 34 * H;  // no bank switch

    initial begin
        int s0, n0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(bus_clk == 1 && bus_rw == 0 && bus_data_oe == 0 && busy == 0 && done == 0,
            "R10 reset levels", {bus_clk, bus_rw, bus_data_oe, busy}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R2 first access switches bank; R5 write order
        access(1, 5'h03, 8'hA5, LS, 8'h00, "R3 first write");
        chk(nsw == 1, "R3 switch count", nsw, 1);
        chk(mem[1][3] == 8'hA5, "R5 write bank1", int'(mem[1][3]), 'hA5);
        access(1, 5'h05, 8'h3C, LN, 8'h00, "R2 same bank");
        chk(nsw == 1, "R2 no extra switch", nsw, 1);
        // R1 upper bank
        access(1, 5'h13, 8'h5A, LS, 8'h00, "R1 upper write");
        chk(mem[2][3] == 8'h5A && mem[1][3] == 8'hA5, "R1 bank split", int'(mem[2][3]), 'h5A);
        chk(nsw == 2, "R2 switch to bank2", nsw, 2);
        // R6 reads
        access(0, 5'h03, 8'h00, LS, 8'hA5, "R6 read bank1");
        access(0, 5'h05, 8'h00, LN, 8'h3C, "R6 read same bank");
        access(0, 5'h1F, 8'h00, LS, 8'h8F, "R1 read top address");
        access(0, 5'h13, 8'h00, LN, 8'h5A, "R6 read bank2");
        chk(nsw == 4, "R2 switch total", nsw, 4);

        // R9 request while busy
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 5'h06; req_wdata = 8'h11;
        @(posedge clk); #1;
        q_acc.push_back(cyc); q_lat.push_back(LS); q_rd.push_back(8'h00); q_tag.push_back("R9 first");
        @(negedge clk);
        req = 1'b0;
        repeat (10) @(negedge clk);
        req = 1'b1; req_addr = 5'h07; req_wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        while (q_acc.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(mem[1][7] == 8'h47, "R9 ignored write", int'(mem[1][7]), 'h47);
        chk(mem[1][6] == 8'h11, "R9 first write kept", int'(mem[1][6]), 'h11);

        // R8 unpowered
        powered = 1'b0;
        s0 = nsw; n0 = nbytes;
        access(1, 5'h08, 8'h77, 0, 8'h00, "R8 unpowered write");
        access(0, 5'h06, 8'h00, 0, 8'h00, "R8 unpowered read");
        chk(nbytes == n0 && nsw == s0, "R8 no bus bytes", nbytes - n0, 0);
        chk(mem[1][8] == 8'h48, "R8 reg untouched", int'(mem[1][8]), 'h48);

        // R3 power back up forces switch even to same bank
        powered = 1'b1;
        repeat (3) @(negedge clk);
        access(0, 5'h06, 8'h00, LS, 8'h11, "R3 read after power up");
        chk(nsw == s0 + 1, "R3 reselect after power", nsw - s0, 1);

        // R4 timing and framing
        chk(bad_low == 0, "R4 clock low width", bad_low, 0);
        chk(merr == 0, "R5 framing", merr, 0);
        chk(bus_clk == 1 && bus_rw == 0 && bus_data_oe == 0, "R10 idle levels",
            {bus_clk, bus_rw, bus_data_oe}, 3'b100);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule